// File: doc/BRIEF.md
# Serial Line Receiver with Error Flags and Idle Timeout

This block turns an asynchronous serial line into received words. A clock enable at sixteen times the baud rate paces it. The line first passes through a two-flop synchronizer. A falling edge is confirmed as a start bit only if the line is still low at the midpoint of that bit. After that, every later bit is sampled at its own midpoint. The frame format comes from plain configuration pins and must be changed only while the line is idle:

- 5 to 8 data bits, sent least significant bit first;
- an optional parity bit, even or odd;
- one or two stop bits.

Each completed word goes into a show-ahead receive FIFO. The FIFO is read through a valid/ready stream:

- `rd_valid` is high whenever a word is held.
- `rd_data` always shows the oldest word.
- A word leaves the FIFO on a clock edge where both `rd_valid` and `rd_ready` are high.
- While the consumer holds `rd_ready` low, `rd_valid` and `rd_data` stay unchanged.
- The receiver cannot be stalled. When the FIFO is full, a newly arriving word is dropped and the overrun flag is set.

Four sticky error flags record problems on the line: overrun, parity, frame and break. A pulse on `clr_status` clears all four. An idle timeout output tells the consumer that words have been waiting in the FIFO for three frame times with no activity.

Top module: `serial_rx`

## Requirements
- R1: The data width is n = cfg_dbits + 5, so code 0 gives 5 bits and code 3 gives 8 bits. Data bits arrive least significant bit first. A stored word holds them in rd_data[n-1:0], and its unused upper bits read as 0.
- R2: When cfg_par_en is 1, one parity bit follows the data. With cfg_par_odd = 0 (even parity) the expected parity bit is the XOR of the data bits. With cfg_par_odd = 1 (odd parity) it is the inverse of that XOR. The frame ends with one stop bit, or with two stop bits when cfg_stop2 is 1.
- R3: A received parity bit that differs from the expected value sets err_parity. The word is still stored.
- R4: A stop bit sampled as 0 sets err_frame. The word is still stored.
- R5: A frame whose every sample is 0, from the start bit through the last stop bit, is a break. A break sets err_break, stores no word, and sets neither err_parity nor err_frame. After a break, the next start bit is searched for only once the line has returned high.
- R6: A low pulse that ends before the midpoint of a start bit is ignored: no word is stored and no flag is set.
- R7: All four error flags are sticky. A one-cycle pulse on clr_status clears them. When a new error occurs in the same cycle as the clear, the new error wins.
- R8: rx_timeout is raised when the FIFO is not empty and no word has been stored or read for 3 × 16 × F baud ticks. F is the frame length in bits: 1 + n + (1 if parity is enabled) + (number of stop bits). rx_timeout clears on the cycle after a read or a store.
- R9: A word that arrives while the FIFO holds DEPTH words, with no read in the same cycle, is discarded and sets err_overrun. The words already stored are kept and are read out in arrival order.
- R10: rd_valid is high exactly when the FIFO holds a word, and rd_data shows the oldest word. A word is removed on a clock edge where rd_valid and rd_ready are both high. While rd_ready is low, rd_valid and rd_data hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input; idles high |
| tick16 | input | 1 | Clock enable at 16 times the baud rate |
| cfg_dbits | input | 2 | Data width code; width is code + 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 for odd parity, 0 for even parity |
| cfg_stop2 | input | 1 | Two stop bits |
| clr_status | input | 1 | Clears the sticky error flags |
| rd_data | output | 8 | Oldest word held in the FIFO |
| rd_valid | output | 1 | FIFO holds a word |
| rd_ready | input | 1 | Consumer accepts rd_data this cycle |
| err_overrun | output | 1 | Sticky: a word was lost because the FIFO was full |
| err_parity | output | 1 | Sticky: a parity mismatch was seen |
| err_frame | output | 1 | Sticky: a stop bit was sampled as 0 |
| err_break | output | 1 | Sticky: a break was seen |
| rx_timeout | output | 1 | Words are waiting and the line has been idle |

## Verification
The properties assume that the configuration pins change only while the receiver is idle between frames, and that tick16 is a single-cycle enable, never high for two cycles in a row. The bench keeps within these limits in three ways:
- It sets the frame format before each frame and leaves it alone until the line has idled for a bit time.
- It drives tick16 on alternate clocks.
- It holds every line level for a whole number of bit times, except for the deliberate glitch and the shortened bad stop bit.

The bench's consumer raises rd_ready only after it has sampled rd_valid. The hold property therefore sees real back-pressure stretches.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
  } rx_state_t;

  // frame length in bits: start + data + parity + stops
  function automatic int frame_bits(input logic [1:0] dbits, input logic par_en,
                                    input logic stop2);
    return 1 + (5 + int'(dbits)) + int'(par_en) + 1 + int'(stop2);
  endfunction
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b1;
      dout <= 1'b1;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic [1:0] cfg_dbits,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  output logic       done,
  output logic [7:0] word,
  output logic       par_err,
  output logic       frm_err,
  output logic       brk
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_t      state;
  logic [CW-1:0]  cnt;
  logic [2:0]     bidx;
  logic [7:0]     shreg;
  logic           allzero, stop_idx, stop_bad, par_bit;
  logic           allz_n, stop_bad_n, par_exp;
  logic [2:0]     last_idx;

  always_comb begin
    allz_n     = allzero & ~rx;
    stop_bad_n = stop_bad | ~rx;
    par_exp    = (^shreg) ^ cfg_par_odd;
    last_idx   = 3'(cfg_dbits) + 3'd4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      shreg    <= '0;
      allzero  <= 1'b1;
      stop_idx <= 1'b0;
      stop_bad <= 1'b0;
      par_bit  <= 1'b0;
      done     <= 1'b0;
      word     <= '0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      brk      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_BRK) begin
        if (rx) state <= ST_IDLE;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
        case (state)
          ST_IDLE: if (!rx) begin
            state <= ST_START;
            cnt   <= '0;
          end
          ST_START: if (cnt == MID) begin
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            allzero  <= 1'b1;
            stop_idx <= 1'b0;
            stop_bad <= 1'b0;
            state    <= rx ? ST_IDLE : ST_DATA;
          end
          ST_DATA: if (cnt == LAST) begin
            shreg[bidx] <= rx;
            allzero     <= allz_n;
            bidx        <= bidx + 1'b1;
            if (bidx == last_idx) state <= cfg_par_en ? ST_PAR : ST_STOP;
          end
          ST_PAR: if (cnt == LAST) begin
            par_bit <= rx;
            allzero <= allz_n;
            state   <= ST_STOP;
          end
          ST_STOP: if (cnt == LAST) begin
            if (cfg_stop2 && !stop_idx) begin
              stop_idx <= 1'b1;
              stop_bad <= stop_bad_n;
              allzero  <= allz_n;
            end else begin
              done    <= 1'b1;
              word    <= shreg;
              brk     <= allz_n;
              frm_err <= stop_bad_n & ~allz_n;
              par_err <= cfg_par_en & (par_bit != par_exp) & ~allz_n;
              state   <= allz_n ? ST_BRK : ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      level <= level + LW'(wr_en) - LW'(rd_en);
    end
  end
endmodule

// File: rtl/serial_rx_timeout.sv
module serial_rx_timeout
  import serial_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int WORDS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       nonempty,
  input  logic       activity,
  input  logic [1:0] cfg_dbits,
  input  logic       cfg_par_en,
  input  logic       cfg_stop2,
  output logic       timeout
);
  localparam int TMAX = WORDS * OSR * 12;
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0] cnt, limit;

  assign limit   = TW'(WORDS * OSR * frame_bits(cfg_dbits, cfg_par_en, cfg_stop2));
  assign timeout = nonempty && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (activity || !nonempty) cnt <= '0;
    else if (tick && cnt < limit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int DEPTH = 8,
  parameter int OSR   = 16,
  parameter int WORDS = 3,
  localparam int LVW  = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       tick16,
  input  logic [1:0] cfg_dbits,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       clr_status,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic       err_overrun,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_break,
  output logic       rx_timeout
);
  logic           rx_s, frm_done, frm_par, frm_bad, frm_brk;
  logic [7:0]     frm_word;
  logic [LVW-1:0] level;
  logic           full, empty, pop, push, accept;

  serial_rx_sync u_sync (.clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s));

  serial_rx_deframer #(.OSR(OSR)) u_deframe (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
    .cfg_dbits(cfg_dbits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .done(frm_done), .word(frm_word),
    .par_err(frm_par), .frm_err(frm_bad), .brk(frm_brk)
  );

  assign pop      = rd_valid && rd_ready;
  assign push     = frm_done && !frm_brk;
  assign accept   = push && (!full || pop);
  assign rd_valid = !empty;

  serial_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_data(frm_word),
    .rd_en(pop), .rd_data(rd_data), .level(level), .full(full), .empty(empty)
  );

  serial_rx_timeout #(.OSR(OSR), .WORDS(WORDS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .nonempty(!empty),
    .activity(accept || pop), .cfg_dbits(cfg_dbits), .cfg_par_en(cfg_par_en),
    .cfg_stop2(cfg_stop2), .timeout(rx_timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_overrun <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_break   <= 1'b0;
    end else begin
      err_overrun <= (err_overrun && !clr_status) || (push && !accept);
      err_parity  <= (err_parity  && !clr_status) || (push && frm_par);
      err_frame   <= (err_frame   && !clr_status) || (push && frm_bad);
      err_break   <= (err_break   && !clr_status) || (frm_done && frm_brk);
    end
  end
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    rd_data,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          clr_status,
  input logic          err_overrun,
  input logic          err_parity,
  input logic          err_frame,
  input logic          err_break,
  input logic          rx_timeout,
  input logic          frm_done,
  input logic          frm_brk,
  input logic [LW-1:0] level
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  p_parity_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity && !clr_status |=> err_parity);

  p_frame_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame && !clr_status |=> err_frame);

  p_break_nostore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && frm_brk && !(rd_valid && rd_ready) |=> $stable(level));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status && !frm_done |=> !err_parity && !err_frame && !err_break && !err_overrun);

  p_timeout_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |-> rd_valid);

  p_overrun_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rd_valid));
endmodule

bind serial_rx serial_rx_chk #(.LW(LVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .clr_status(clr_status), .err_overrun(err_overrun),
  .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
  .rx_timeout(rx_timeout), .frm_done(frm_done), .frm_brk(frm_brk), .level(level)
);

// File: tb/serial_rx_test.sv
`timescale 1ns/1ps
module serial_rx_test;
  localparam int BITC = 32; // 16 ticks, one tick every 2 clocks

  logic clk = 1'b0, rst_n = 1'b0, rx_line = 1'b1, tick16 = 1'b0;
  logic [1:0] cfg_dbits = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic clr_status = 1'b0, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid, err_overrun, err_parity, err_frame, err_break, rx_timeout;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;
  always @(negedge clk) tick16 <= ~tick16;

  serial_rx uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int clocks);
    rx_line = v;
    repeat (clocks) @(negedge clk);
  endtask

  // drives one frame with the current cfg; optionally corrupts parity or stop
  task automatic send(input logic [7:0] d, input bit flip_par, input bit bad_stop, input bit keep);
    int n = int'(cfg_dbits) + 5;
    logic [7:0] m = d & 8'((1 << n) - 1);
    hold(1'b0, BITC);
    for (int i = 0; i < n; i++) hold(m[i], BITC);
    if (cfg_par_en) hold((^m) ^ cfg_par_odd ^ flip_par, BITC);
    if (bad_stop) begin
      hold(1'b0, 22);
      hold(1'b1, BITC - 22);
    end else hold(1'b1, BITC);
    if (cfg_stop2) hold(1'b1, BITC);
    hold(1'b1, BITC);
    if (keep) exp_q.push_back(m);
  endtask

  task automatic pop_check(input string req);
    logic [7:0] first;
    int guard = 0;
    while (!rd_valid && guard < 2000) begin @(negedge clk); guard++; end
    check(req, {31'd0, rd_valid}, 32'd1);
    first = rd_data;
    repeat (3) @(negedge clk);
    check("R10", {24'd0, rd_data}, {24'd0, first});
    if (exp_q.size() > 0) check(req, {24'd0, rd_data}, {24'd0, exp_q.pop_front()});
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic pulse_clear();
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset valid", {31'd0, rd_valid}, 32'd0);
    check("R7 reset flags", {28'd0, err_overrun, err_parity, err_frame, err_break}, 32'd0);
    check("R8 reset timeout", {31'd0, rx_timeout}, 32'd0);

    // R1: 8N1
    send(8'hA5, 0, 0, 1);
    pop_check("R1 8N1");
    check("R10 empty after pop", {31'd0, rd_valid}, 32'd0);

    // R2: 5 bits, even parity; upper bits zero
    cfg_dbits = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send(8'hF5, 0, 0, 1);
    pop_check("R2 5E1");
    // R2: 7 bits odd parity 2 stop
    cfg_dbits = 2'd2; cfg_par_odd = 1'b1; cfg_stop2 = 1'b1;
    send(8'h4B, 0, 0, 1);
    pop_check("R2 7O2");
    check("R2 no parity err", {31'd0, err_parity}, 32'd0);

    // R3: parity error, word kept
    send(8'h33, 1, 0, 1);
    check("R3 parity flag", {31'd0, err_parity}, 32'd1);
    pop_check("R3 word kept");
    repeat (5) @(negedge clk);
    check("R3 sticky", {31'd0, err_parity}, 32'd1);
    pulse_clear();
    check("R7 clear", {31'd0, err_parity}, 32'd0);

    // R4: frame error, word kept
    cfg_dbits = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
    send(8'h5A, 0, 1, 1);
    hold(1'b1, 2 * BITC);
    check("R4 frame flag", {31'd0, err_frame}, 32'd1);
    pop_check("R4 word kept");
    check("R6 tail glitch stored nothing", {31'd0, rd_valid}, 32'd0);
    pulse_clear();

    // R5: break
    hold(1'b0, 14 * BITC);
    hold(1'b1, 2 * BITC);
    check("R5 break flag", {31'd0, err_break}, 32'd1);
    check("R5 no word", {31'd0, rd_valid}, 32'd0);
    check("R5 no frame err", {30'd0, err_frame, err_parity}, 32'd0);
    pulse_clear();

    // R6: start glitch
    hold(1'b0, 6);
    hold(1'b1, 3 * BITC);
    check("R6 glitch no word", {31'd0, rd_valid}, 32'd0);
    check("R6 glitch no flag", {28'd0, err_overrun, err_parity, err_frame, err_break}, 32'd0);

    // R8: timeout for 8N1 = 480 ticks = 960 clocks after store
    send(8'h3C, 0, 0, 1);
    repeat (850) @(negedge clk);
    check("R8 not yet", {31'd0, rx_timeout}, 32'd0);
    repeat (150) @(negedge clk);
    check("R8 raised", {31'd0, rx_timeout}, 32'd1);
    pop_check("R8 word");
    check("R8 cleared by read", {31'd0, rx_timeout}, 32'd0);

    // R9: overrun with DEPTH 8
    for (int i = 0; i < 9; i++) send(8'(8'h10 + i), 0, 0, i < 8);
    check("R9 overrun flag", {31'd0, err_overrun}, 32'd1);
    for (int i = 0; i < 8; i++) pop_check("R9 order");
    check("R9 ninth dropped", {31'd0, rd_valid}, 32'd0);
    pulse_clear();
    check("R7 clear overrun", {31'd0, err_overrun}, 32'd0);

    finish_run();
  end
endmodule